// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst in a synchronous pipelined memory. A burst starts when either of two load strobes is seen at a rising clock edge. The block then registers the whole external address and sets its beat index to zero. The processor-side strobe only loads while the bank enable is also low. The controller-side strobe always loads.

On later cycles, a low advance input steps the beat index. A high advance input makes a wait cycle, and the address holds. Only the low two address bits come from the beat index. The upper bits keep their loaded value.

A static order input is captured during reset and picks how the low bits are formed:
- Linear order adds the beat to the loaded low bits, modulo four.
- Interleaved order XORs the beat with the loaded low bits.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_ni` is low, each rising clock edge clears the address and the beat index to zero.
- R2: When `proc_strb_ni` and `bank_en_ni` are both low at a rising edge, `addr_o` takes `ext_addr_i` and `beat_o` becomes 0 after that edge.
- R3: When `proc_strb_ni` is low but `bank_en_ni` is high, and `ctrl_strb_ni` and `adv_ni` are high, `addr_o` and `beat_o` are unchanged.
- R4: When `ctrl_strb_ni` is low at a rising edge, `addr_o` takes `ext_addr_i` and `beat_o` becomes 0, whatever the level of `bank_en_ni`.
- R5: With no load, a low `adv_ni` raises `beat_o` by one modulo 4, so the fourth advance returns the address to its starting value.
- R6: With no load, a high `adv_ni` is a wait cycle: `addr_o` and `beat_o` hold.
- R7: In linear order (`order_sel_i` = 0 during reset), the low two bits of `addr_o` equal the loaded low bits plus `beat_o`, modulo 4.
- R8: In interleaved order (`order_sel_i` = 1 during reset), the low two bits of `addr_o` equal the loaded low bits XOR `beat_o`.
- R9: Between loads, the address bits above the low two never change.
- R10: A load in the same cycle as a low `adv_ni` wins: the new address is loaded and `beat_o` becomes 0.
- R11: `order_sel_i` is sampled only while in reset. Changing it after reset does not change the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| bank_en_ni | input | 1 | Bank enable, active low; qualifies the processor strobe |
| proc_strb_ni | input | 1 | Processor-side address load strobe, active low |
| ctrl_strb_ni | input | 1 | Controller-side address load strobe, active low |
| adv_ni | input | 1 | Burst advance, active low; high makes a wait cycle |
| order_sel_i | input | 1 | Burst order, sampled in reset: 0 linear, 1 interleaved |
| ext_addr_i | input | ADDR_W | External address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | BURST_BITS | Beat index within the burst |

## Verification
The bench builds the block with `ADDR_W` = 12 and the default `BURST_BITS` = 2. The narrow address keeps the values readable, while the upper ten bits are still enough to show that a wrap never carries into them.

With two counter bits, each burst wraps after four steps. That puts the wrap, the linear carry from 3 to 0 and the interleaved reorder all within a few cycles of a load. One start value is chosen so that linear and interleaved order give different addresses, so a change of order after reset would be seen.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_load_ctrl.sv
// Decides load / step / wait and forms the next beat index.
module bseq_load_ctrl #(
    parameter int BURST_BITS = 2
) (
    input  logic                  bank_en_ni,
    input  logic                  proc_strb_ni,
    input  logic                  ctrl_strb_ni,
    input  logic                  adv_ni,
    input  logic [BURST_BITS-1:0] beat_q,
    output logic                  load_o,
    output logic [BURST_BITS-1:0] beat_d
);
    logic proc_take;

    always_comb begin
        proc_take = !proc_strb_ni && !bank_en_ni;
        load_o    = proc_take || !ctrl_strb_ni;
        if (load_o) begin
            beat_d = '0;
        end else if (!adv_ni) begin
            beat_d = beat_q + 1'b1;
        end else begin
            beat_d = beat_q;
        end
    end
endmodule

// File: rtl/bseq_order_map.sv
// Maps start bits and beat index to the low address bits.
module bseq_order_map
    import bseq_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  order_e                order_i,
    input  logic [BURST_BITS-1:0] start_i,
    input  logic [BURST_BITS-1:0] beat_i,
    output logic [BURST_BITS-1:0] low_o
);
    logic [BURST_BITS-1:0] lin_low;
    logic [BURST_BITS-1:0] ilv_low;

    for (genvar b = 0; b < BURST_BITS; b++) begin : g_ilv
        assign ilv_low[b] = start_i[b] ^ beat_i[b];
    end

    always_comb begin
        lin_low = start_i + beat_i;
        low_o   = (order_i == ORD_INTERLEAVE) ? ilv_low : lin_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bank_en_ni,
    input  logic                  proc_strb_ni,
    input  logic                  ctrl_strb_ni,
    input  logic                  adv_ni,
    input  logic                  order_sel_i,
    input  logic [ADDR_W-1:0]     ext_addr_i,
    output logic [ADDR_W-1:0]     addr_o,
    output logic [BURST_BITS-1:0] beat_o
);
    localparam int HI_W = ADDR_W - BURST_BITS;

    typedef struct packed {
        logic [ADDR_W-1:0]     base;
        logic [BURST_BITS-1:0] beat;
        order_e                order;
    } seq_state_t;

    seq_state_t            seq_d, seq_q;
    logic                  load;
    logic [BURST_BITS-1:0] beat_next;
    logic [BURST_BITS-1:0] low_bits;

    bseq_load_ctrl #(.BURST_BITS(BURST_BITS)) i_ctrl (
        .bank_en_ni  (bank_en_ni),
        .proc_strb_ni(proc_strb_ni),
        .ctrl_strb_ni(ctrl_strb_ni),
        .adv_ni      (adv_ni),
        .beat_q      (seq_q.beat),
        .load_o      (load),
        .beat_d      (beat_next)
    );

    bseq_order_map #(.BURST_BITS(BURST_BITS)) i_map (
        .order_i(seq_q.order),
        .start_i(seq_q.base[BURST_BITS-1:0]),
        .beat_i (seq_q.beat),
        .low_o  (low_bits)
    );

    always_comb begin
        seq_d = seq_q;
        if (!rst_ni) begin
            seq_d.base  = '0;
            seq_d.beat  = '0;
            seq_d.order = order_e'(order_sel_i);
        end else begin
            seq_d.beat = beat_next;
            if (load) begin
                seq_d.base = ext_addr_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        seq_q <= seq_d;
    end

    assign addr_o = {seq_q.base[ADDR_W-1 -: HI_W], low_bits};
    assign beat_o = seq_q.beat;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  bank_en_ni,
    input logic                  proc_strb_ni,
    input logic                  ctrl_strb_ni,
    input logic                  adv_ni,
    input logic [ADDR_W-1:0]     ext_addr_i,
    input logic [ADDR_W-1:0]     addr_o,
    input logic [BURST_BITS-1:0] beat_o
);
    logic ld;
    assign ld = (!proc_strb_ni && !bank_en_ni) || !ctrl_strb_ni;

    p_proc_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!proc_strb_ni && !bank_en_ni) |=> (addr_o == $past(ext_addr_i)) && (beat_o == '0));

    p_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!proc_strb_ni && bank_en_ni && ctrl_strb_ni && adv_ni) |=> $stable(addr_o) && $stable(beat_o));

    p_ctrl_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_strb_ni |=> (addr_o == $past(ext_addr_i)) && (beat_o == '0));

    p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld && !adv_ni) |=> beat_o == BURST_BITS'($past(beat_o) + 1'b1));

    p_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld && adv_ni) |=> $stable(addr_o) && $stable(beat_o));

    p_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld |=> addr_o[ADDR_W-1:BURST_BITS] == $past(addr_o[ADDR_W-1:BURST_BITS]));

    p_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld && !adv_ni) |=> beat_o == '0);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bank_en_ni  (bank_en_ni),
    .proc_strb_ni(proc_strb_ni),
    .ctrl_strb_ni(ctrl_strb_ni),
    .adv_ni      (adv_ni),
    .ext_addr_i  (ext_addr_i),
    .addr_o      (addr_o),
    .beat_o      (beat_o)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int AW = 12;
    localparam int BB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bank_n = 1'b1, proc_n = 1'b1, ctrl_n = 1'b1, adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] ext = '0;
    logic [AW-1:0] addr;
    logic [BB-1:0] beat;
    int            n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(BB)) i_burst_addr_seq (
        .clk_i(clk), .rst_ni(rst_n), .bank_en_ni(bank_n), .proc_strb_ni(proc_n),
        .ctrl_strb_ni(ctrl_n), .adv_ni(adv_n), .order_sel_i(order_sel),
        .ext_addr_i(ext), .addr_o(addr), .beat_o(beat)
    );

    function automatic logic [AW-1:0] model(logic [AW-1:0] b, logic [BB-1:0] n, logic ilv);
        logic [BB-1:0] lo;
        lo = ilv ? (b[BB-1:0] ^ n) : BB'(b[BB-1:0] + n);
        return {b[AW-1:BB], lo};
    endfunction

    task automatic chk(string req, logic [AW-1:0] a_act, logic [AW-1:0] a_exp,
                       logic [BB-1:0] b_act, logic [BB-1:0] b_exp);
        n_chk++;
        if (a_act !== a_exp || b_act !== b_exp) begin
            n_fail++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, a_act, b_act, a_exp, b_exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(logic p, logic c, logic bk, logic av, logic [AW-1:0] x);
        proc_n = p; ctrl_n = c; bank_n = bk; adv_n = av; ext = x;
        @(negedge clk);
        proc_n = 1'b1; ctrl_n = 1'b1; bank_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic do_reset(logic ord);
        order_sel = ord; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", addr, '0, beat, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_burst(string req, logic [AW-1:0] a, logic ilv);
        step(1'b0, 1'b1, 1'b0, 1'b1, a);
        chk("R2 processor load", addr, a, beat, 2'd0);
        for (int i = 1; i <= 4; i++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0, '0);
            chk(i == 4 ? "R5 wrap to start" : req, addr,
                model(a, BB'(i), ilv), beat, BB'(i));
            chk("R9 upper bits", {addr[AW-1:BB], 2'b00}, {a[AW-1:BB], 2'b00}, 2'd0, 2'd0);
        end
    endtask

    task automatic t_wait();
        step(1'b1, 1'b1, 1'b1, 1'b0, '0);
        chk("R5 single step", addr, 12'hA53, beat, 2'd1);
        for (int i = 0; i < 2; i++) begin
            step(1'b1, 1'b1, 1'b1, 1'b1, 12'hFFF);
            chk("R6 wait holds", addr, 12'hA53, beat, 2'd1);
        end
    endtask

    task automatic t_proc_gated();
        step(1'b0, 1'b1, 1'b1, 1'b1, 12'h3C1);
        chk("R3 gated strobe ignored", addr, 12'hA53, beat, 2'd1);
    endtask

    task automatic t_ctrl_load();
        step(1'b1, 1'b0, 1'b1, 1'b1, 12'h3C1);
        chk("R4 controller load", addr, 12'h3C1, beat, 2'd0);
    endtask

    task automatic t_priority();
        step(1'b1, 1'b1, 1'b1, 1'b0, '0);
        chk("R5 step before priority", addr, 12'h3C2, beat, 2'd1);
        step(1'b1, 1'b0, 1'b1, 1'b0, 12'h7F3);
        chk("R10 load beats advance", addr, 12'h7F3, beat, 2'd0);
    endtask

    task automatic t_mode_static();
        order_sel = 1'b1;
        step(1'b1, 1'b1, 1'b1, 1'b0, '0);
        chk("R11 order unchanged after reset", addr, 12'h7F0, beat, 2'd1);
        step(1'b1, 1'b1, 1'b1, 1'b0, '0);
        chk("R11 order unchanged after reset", addr, 12'h7F1, beat, 2'd2);
    endtask

    initial begin
        #(20000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        t_burst("R7 linear order", 12'hA52, 1'b0);
        t_wait();
        t_proc_gated();
        t_ctrl_load();
        t_priority();
        t_mode_static();
        do_reset(1'b1);
        t_burst("R8 interleaved order", 12'h5A1, 1'b1);
        t_burst("R8 interleaved order", 12'h5A2, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule